// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This block holds two independent periodic timers. Each timer cascades two 16-bit down-counting stages. The first stage is a prescaler that counts from its load value P down to zero and then reloads. The second stage is a divider that steps down by one each time the prescaler wraps. When both stages reach zero together, the timer has expired. It then reloads both stages and carries on, so its period is (P+1)·(D+1) clock cycles. It never stops, including when P and D are both zero. An expiry raises that timer's interrupt request, but only when the interrupt is enabled. The request stays latched until software clears it.

Software reaches the block through a 16-bit register port. Each word has two byte lane strobes, and the high lane stands for the even byte address. Writing any lane of a timer's prescaler or divider register restarts that timer at once with the new values. Separate read-only words return the live count of each stage. A control word holds the enable bits and takes write-one-to-clear requests.

Each timer is a small machine with three phases, decoded from its counts. PH_PRESCALE applies while the prescaler count is nonzero, and the count decrements by one. PH_STEP applies while the prescaler is zero and the divider is nonzero: the prescaler reloads P and the divider decrements. PH_EXPIRE applies while both counts are zero: both stages reload and an expiry is issued. A restart write overrides every phase.

Each interrupt source has a two-state latch. It moves from IRQ_IDLE to IRQ_PENDING on an enabled expiry. It moves from IRQ_PENDING back to IRQ_IDLE on a clear, but only when no enabled expiry arrives in the same cycle.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, all four prescaler/divider words read 0xFFFF, all four live-count words read 0xFFFF, the control word reads 0x0000 and both `irq` bits are 0.
- R2: With its interrupt enabled, timer t raises `irq[t]` exactly (P+1)·(D+1) rising edges after the edge that restarted it. It raises it again every (P+1)·(D+1) edges after that, and with P=D=0 it expires on every edge.
- R3: Live counts follow the cascade. k edges after a restart with P and D, the prescaler count reads P − (k mod (P+1)) and the divider count reads D − (⌊k/(P+1)⌋ mod (D+1)).
- R4: A write strobe on either lane of a timer's prescaler word (word 2t) or divider word (word 2t+1) reloads both of its stages with the resulting values on that same edge. An expiry due in that cycle is discarded.
- R5: `bus_be[1]` writes bits 15:8 of the addressed word (the even byte) and `bus_be[0]` writes bits 7:0 (the odd byte). Both strobes together replace the whole word, and an unstrobed lane keeps its value.
- R6: Word 5+2t returns timer t's live prescaler count and word 6+2t returns its live divider count. Writes to these words change nothing.
- R7: Control word 4, low lane: bit t enables interrupt t. An expiry while bit t is 0 leaves `irq[t]` low.
- R8: `irq[t]` stays high through further expiries until a write to word 4 with the high lane strobed and bit 8+t set. A write with that bit 0 leaves it high. Bits 8+t of a control word read show the pending state.
- R9: An enabled expiry in the same cycle as a clear wins, so the request stays set.
- R10: Writes addressed to one timer do not disturb the other timer's counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (4) | Word index of the register being accessed (byte offset = 2·index) |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_be | input | 2 | Lane strobes: bit 1 = even byte (bits 15:8), bit 0 = odd byte (bits 7:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data of the addressed word |
| irq | output | NUM_TMR (2) | Latched interrupt request per timer |

## Verification
The bound checker checks the cascade every cycle. A restart loads both stages, and a restart masks any expiry in the same cycle. The prescaler decrements by one in its counting phase, and the divider steps by one with the prescaler reload. A request can only rise after an enabled expiry, it holds until cleared, and an enabled expiry always wins over a clear.

Only the bench's scenarios can show the things that need a count across many cycles. That covers exact periods across a sweep of small P and D for both timers, live counts sampled at chosen offsets, and the byte-lane merge. It also covers masking while disabled, and the separation of the two timers.

// File: rtl/dit_pkg.sv
`timescale 1ns/1ps
package dit_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef logic [DATA_W-1:0] word_t;

    localparam word_t RESET_LOAD = '1;

    // Phase of one cascaded timer, decoded from its two counts
    typedef enum logic [1:0] {
        PH_PRESCALE = 2'd0,
        PH_STEP     = 2'd1,
        PH_EXPIRE   = 2'd2
    } phase_e;

    // Per-source interrupt latch
    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

    // Merge write data into a word according to the lane strobes
    function automatic word_t merge_lanes(word_t cur, word_t nw, logic [1:0] be);
        word_t res;
        res[DATA_W-1:BYTE_W] = be[1] ? nw[DATA_W-1:BYTE_W] : cur[DATA_W-1:BYTE_W];
        res[BYTE_W-1:0]      = be[0] ? nw[BYTE_W-1:0]      : cur[BYTE_W-1:0];
        return res;
    endfunction
endpackage

// File: rtl/dit_regfile.sv
`timescale 1ns/1ps
module dit_regfile
    import dit_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [1:0]               bus_be,
    input  word_t                    bus_wdata,
    output word_t                    bus_rdata,
    input  word_t [NUM_TMR-1:0]      live_pre,
    input  word_t [NUM_TMR-1:0]      live_div,
    input  logic  [NUM_TMR-1:0]      irq_pend,
    output word_t [NUM_TMR-1:0]      pre_next,
    output word_t [NUM_TMR-1:0]      div_next,
    output logic  [NUM_TMR-1:0]      restart,
    output logic  [NUM_TMR-1:0]      irq_en,
    output logic  [NUM_TMR-1:0]      irq_clr
);
    localparam int CTRL_IDX  = 2 * NUM_TMR;
    localparam int LIVE_BASE = CTRL_IDX + 1;

    word_t [NUM_TMR-1:0] pre_cur;
    word_t [NUM_TMR-1:0] div_cur;
    logic  [NUM_TMR-1:0] en_q;
    logic                lane_any;
    logic                hit_ctrl;

    assign lane_any = |bus_be;
    assign hit_ctrl = bus_wr && lane_any && (bus_addr == ADDR_W'(CTRL_IDX));

    // Per-timer period registers
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr_regs
        localparam logic [ADDR_W-1:0] PRE_IDX = ADDR_W'(2 * t);
        localparam logic [ADDR_W-1:0] DIV_IDX = ADDR_W'(2 * t + 1);

        word_t pre_q;
        word_t div_q;
        logic  hit_pre;
        logic  hit_div;

        assign hit_pre = bus_wr && lane_any && (bus_addr == PRE_IDX);
        assign hit_div = bus_wr && lane_any && (bus_addr == DIV_IDX);

        assign pre_next[t] = hit_pre ? merge_lanes(pre_q, bus_wdata, bus_be) : pre_q;
        assign div_next[t] = hit_div ? merge_lanes(div_q, bus_wdata, bus_be) : div_q;
        assign restart[t]  = hit_pre || hit_div;
        assign pre_cur[t]  = pre_q;
        assign div_cur[t]  = div_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q <= RESET_LOAD;
                div_q <= RESET_LOAD;
            end else begin
                pre_q <= pre_next[t];
                div_q <= div_next[t];
            end
        end
    end

    // Interrupt enables (low lane of the control word)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (hit_ctrl && bus_be[0]) begin
            en_q <= bus_wdata[NUM_TMR-1:0];
        end
    end

    assign irq_en  = en_q;
    assign irq_clr = (hit_ctrl && bus_be[1]) ? bus_wdata[BYTE_W +: NUM_TMR] : '0;

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            if (bus_addr == ADDR_W'(2 * t))             bus_rdata = pre_cur[t];
            if (bus_addr == ADDR_W'(2 * t + 1))         bus_rdata = div_cur[t];
            if (bus_addr == ADDR_W'(LIVE_BASE + 2 * t)) bus_rdata = live_pre[t];
            if (bus_addr == ADDR_W'(LIVE_BASE + 2 * t + 1)) bus_rdata = live_div[t];
        end
        if (bus_addr == ADDR_W'(CTRL_IDX)) begin
            bus_rdata[NUM_TMR-1:0]          = en_q;
            bus_rdata[BYTE_W +: NUM_TMR]    = irq_pend;
        end
    end
endmodule

// File: rtl/dit_cascade_counter.sv
`timescale 1ns/1ps
module dit_cascade_counter
    import dit_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  word_t pre_val,
    input  word_t div_val,
    output word_t cnt_pre,
    output word_t cnt_div,
    output logic  expire
);
    word_t  pre_q;
    word_t  div_q;
    phase_e phase;

    // Phase decode from the two stage counts
    always_comb begin
        if (pre_q != '0) begin
            phase = PH_PRESCALE;
        end else if (div_q != '0) begin
            phase = PH_STEP;
        end else begin
            phase = PH_EXPIRE;
        end
    end

    // State register: both stage counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= RESET_LOAD;
            div_q <= RESET_LOAD;
        end else if (restart) begin
            pre_q <= pre_val;
            div_q <= div_val;
        end else begin
            unique case (phase)
                PH_PRESCALE: begin
                    pre_q <= pre_q - 1'b1;
                end
                PH_STEP: begin
                    pre_q <= pre_val;
                    div_q <= div_q - 1'b1;
                end
                PH_EXPIRE: begin
                    pre_q <= pre_val;
                    div_q <= div_val;
                end
                default: begin
                    pre_q <= pre_q;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        cnt_pre = pre_q;
        cnt_div = div_q;
        expire  = (phase == PH_EXPIRE) && !restart;
    end
endmodule

// File: rtl/dit_irq_latch.sv
`timescale 1ns/1ps
module dit_irq_latch
    import dit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pending
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (set)          state_d = IRQ_PENDING;
            IRQ_PENDING: if (clr && !set)  state_d = IRQ_IDLE;
            default:                       state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == IRQ_PENDING);
    end
endmodule

// File: rtl/dual_interval_timer.sv
`timescale 1ns/1ps
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int NUM_TMR = 2,
    parameter int ADDR_W  = $clog2(4 * NUM_TMR + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [1:0]          bus_be,
    input  logic [15:0]         bus_wdata,
    output logic [15:0]         bus_rdata,
    output logic [NUM_TMR-1:0]  irq
);
    word_t [NUM_TMR-1:0] pre_next;
    word_t [NUM_TMR-1:0] div_next;
    word_t [NUM_TMR-1:0] cnt_pre;
    word_t [NUM_TMR-1:0] cnt_div;
    logic  [NUM_TMR-1:0] restart;
    logic  [NUM_TMR-1:0] expire;
    logic  [NUM_TMR-1:0] irq_en;
    logic  [NUM_TMR-1:0] irq_clr;

    dit_regfile #(
        .NUM_TMR (NUM_TMR),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .live_pre  (cnt_pre),
        .live_div  (cnt_div),
        .irq_pend  (irq),
        .pre_next  (pre_next),
        .div_next  (div_next),
        .restart   (restart),
        .irq_en    (irq_en),
        .irq_clr   (irq_clr)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_timer
        dit_cascade_counter u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart[t]),
            .pre_val (pre_next[t]),
            .div_val (div_next[t]),
            .cnt_pre (cnt_pre[t]),
            .cnt_div (cnt_div[t]),
            .expire  (expire[t])
        );

        dit_irq_latch u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .set     (expire[t] && irq_en[t]),
            .clr     (irq_clr[t]),
            .pending (irq[t])
        );
    end
endmodule

// File: rtl/dit_checker.sv
`timescale 1ns/1ps
module dit_checker
    import dit_pkg::*;
#(
    parameter int NUM_TMR = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic  [NUM_TMR-1:0] restart,
    input logic  [NUM_TMR-1:0] expire,
    input logic  [NUM_TMR-1:0] irq_en,
    input logic  [NUM_TMR-1:0] irq_clr,
    input logic  [NUM_TMR-1:0] irq,
    input word_t [NUM_TMR-1:0] pre_next,
    input word_t [NUM_TMR-1:0] div_next,
    input word_t [NUM_TMR-1:0] cnt_pre,
    input word_t [NUM_TMR-1:0] cnt_div
);
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
        // R4: a restart loads both stages with the resulting register values
        a_r4_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
            restart[t] |=> (cnt_pre[t] == $past(pre_next[t])) && (cnt_div[t] == $past(div_next[t])));

        // R4: a restart discards an expiry in the same cycle
        a_r4_restart_masks_expiry: assert property (@(posedge clk) disable iff (!rst_n)
            restart[t] |-> !expire[t]);

        // R3: prescaler decrements while nonzero
        a_r3_prescale_decrements: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart[t] && cnt_pre[t] != '0) |=>
                (cnt_pre[t] == word_t'($past(cnt_pre[t]) - 1'b1)) && $stable(cnt_div[t]));

        // R3: divider steps once per prescaler wrap, prescaler reloads
        a_r3_divider_steps: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart[t] && cnt_pre[t] == '0 && cnt_div[t] != '0) |=>
                (cnt_div[t] == word_t'($past(cnt_div[t]) - 1'b1)) && (cnt_pre[t] == $past(pre_next[t])));

        // R7: a request only rises after an enabled expiry
        a_r7_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[t]) |-> $past(expire[t] && irq_en[t]));

        // R8: a pending request holds without a clear
        a_r8_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[t] && !irq_clr[t]) |=> irq[t]);

        // R8: a clear with no competing expiry drops the request
        a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[t] && irq_clr[t] && !(expire[t] && irq_en[t])) |=> !irq[t]);

        // R9: an enabled expiry always leaves the request set
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[t] && irq_en[t]) |=> irq[t]);
    end
endmodule

bind dual_interval_timer dit_checker #(.NUM_TMR(NUM_TMR)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .expire   (expire),
    .irq_en   (irq_en),
    .irq_clr  (irq_clr),
    .irq      (irq),
    .pre_next (pre_next),
    .div_next (div_next),
    .cnt_pre  (cnt_pre),
    .cnt_div  (cnt_div)
);

// File: tb/dual_interval_timer_test.sv
`timescale 1ns/1ps
module dual_interval_timer_test;
    localparam int W_CTRL = 4;
    localparam int W_LIVE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    dual_interval_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(int word, logic [1:0] be, logic [15:0] d);
        bus_addr  = word[3:0];
        bus_be    = be;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_be    = '0;
    endtask

    task automatic rd(int word, output int v);
        bus_addr = word[3:0];
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_until(int base, int k);
        while (cyc - base < k) @(negedge clk);
    endtask

    // R2/R9 period measurement for timer t
    task automatic run_period(int t, int p, int d);
        int e0, n, first, second;
        string tag;
        wr(2 * t, 2'b11, 16'(p));
        wr(2 * t + 1, 2'b11, 16'(d));
        e0 = cyc;
        n  = (p + 1) * (d + 1);
        wr(W_CTRL, 2'b10, 16'(1 << (8 + t)));
        first = irq[t] ? (cyc - e0) : -1;
        while (first < 0 && (cyc - e0) < n + 2) begin
            @(negedge clk);
            if (irq[t]) first = cyc - e0;
        end
        tag = (n == 1) ? "R9" : "R2";
        check(tag, $sformatf("t%0d P=%0d D=%0d first expiry", t, p, d), first, n);
        if (n >= 2 && first == n) begin
            wr(W_CTRL, 2'b10, 16'(1 << (8 + t)));
            second = irq[t] ? (cyc - e0) : -1;
            while (second < 0 && (cyc - e0) < 2 * n + 2) begin
                @(negedge clk);
                if (irq[t]) second = cyc - e0;
            end
            check("R2", $sformatf("t%0d P=%0d D=%0d second expiry", t, p, d), second, 2 * n);
        end
    endtask

    initial begin
        #(64'd4_000_000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int v, e1, e2, k;
        int ks[8] = '{1, 4, 6, 7, 13, 23, 24, 30};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, sampled before any edge after release
        for (int w = 0; w < 4; w++) begin
            rd(w, v);
            check("R1", $sformatf("period word %0d", w), v, 16'hFFFF);
        end
        for (int w = W_LIVE; w < W_LIVE + 4; w++) begin
            rd(w, v);
            check("R1", $sformatf("live word %0d", w), v, 16'hFFFF);
        end
        rd(W_CTRL, v);
        check("R1", "control word", v, 0);
        check("R1", "irq", int'(irq), 0);

        @(negedge clk);
        wr(W_CTRL, 2'b01, 16'h0003);

        // Timer 2 reference for R10
        wr(2, 2'b11, 16'd7);
        wr(3, 2'b11, 16'd2);
        e2 = cyc;

        // R3 / R6: timer 1 cascade with P=5, D=3
        wr(0, 2'b11, 16'd5);
        wr(1, 2'b11, 16'd3);
        e1 = cyc;
        wr(W_LIVE, 2'b11, 16'h0000);      // R6: read-only word, write ignored
        foreach (ks[i]) begin
            wait_until(e1, ks[i]);
            k = cyc - e1;
            rd(W_LIVE, v);
            check("R3", $sformatf("t1 prescale count k=%0d", k), v, 5 - (k % 6));
            rd(W_LIVE + 1, v);
            check("R6", $sformatf("t1 divider count k=%0d", k), v, 3 - ((k / 6) % 4));
        end

        // R4: low-lane divider write restarts mid-count (0x0003 -> 0x0001)
        wr(1, 2'b01, 16'h0001);
        e1 = cyc;
        rd(W_LIVE, v);
        check("R4", "prescale reload on restart", v, 5);
        rd(W_LIVE + 1, v);
        check("R4", "divider reload on restart", v, 1);
        wait_until(e1, 3);
        rd(W_LIVE, v);
        check("R4", "prescale after restart k=3", v, 2);

        // R10: timer 2 unaffected by timer 1 traffic
        k = cyc - e2;
        rd(W_LIVE + 2, v);
        check("R10", "t2 prescale count", v, 7 - (k % 8));
        rd(W_LIVE + 3, v);
        check("R10", "t2 divider count", v, 2 - ((k / 8) % 3));

        // R5: byte lanes on timer 2 prescaler
        wr(2, 2'b11, 16'h1234);
        rd(2, v);
        check("R5", "word write", v, 16'h1234);
        wr(2, 2'b10, 16'hAB00);
        rd(2, v);
        check("R5", "even-byte write", v, 16'hAB34);
        wr(2, 2'b01, 16'h00CD);
        rd(2, v);
        check("R5", "odd-byte write", v, 16'hABCD);

        // R7: disabled source stays quiet
        wr(W_CTRL, 2'b01, 16'h0002);
        wr(0, 2'b11, 16'd1);
        wr(1, 2'b11, 16'd1);
        wr(W_CTRL, 2'b10, 16'h0100);
        repeat (10) @(negedge clk);
        check("R7", "irq[0] while disabled", int'(irq[0]), 0);
        rd(W_CTRL, v);
        check("R7", "pending bit while disabled", (v >> 8) & 1, 0);

        // R8: latched across expiries, zero-bit write leaves it
        wr(W_CTRL, 2'b01, 16'h0003);
        repeat (5) @(negedge clk);
        check("R8", "irq[0] after enable", int'(irq[0]), 1);
        repeat (12) @(negedge clk);
        check("R8", "irq[0] held over expiries", int'(irq[0]), 1);
        wr(W_CTRL, 2'b10, 16'h0000);
        check("R8", "irq[0] after zero clear write", int'(irq[0]), 1);
        rd(W_CTRL, v);
        check("R8", "pending bit reads set", (v >> 8) & 1, 1);

        // R2 / R9 sweep over small periods, both timers
        for (int t = 0; t < 2; t++)
            for (int p = 0; p < 4; p++)
                for (int d = 0; d < 4; d++)
                    run_period(t, p, d);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule